// File: doc/BRIEF.md
# Dual Auxiliary Address Generator

This block produces operand addresses for a processor datapath. It holds a shared register set: eight 32-bit pointer registers, two 32-bit index registers and one circular block-length register. Two independent address lanes read from this register set. In any cycle each lane may accept one request. A request names a pointer register, an update mode, an offset source and a direction. The lane returns one address and, for updating modes, writes the modified pointer back. The lanes do not depend on any arithmetic datapath, so two addresses are produced per cycle.

Supported updates:
- Plain offset addressing, with or without write-back.
- Post-modification by an offset.
- Circular post-modification that wraps inside a power-of-two aligned region.
- Bit-reversed post-increment for FFT operand ordering.

The offset is either the request's 8-bit displacement or one of the two index registers. A configuration write port loads the registers. Each lane has a valid/ready handshake on its request side and on its registered address output.

Top module: `aux_addr_gen`

## Requirements
- R1: Reset (synchronous, active high) sets all pointer, index and block-length registers to zero, clears both `out_valid` bits, and leaves both `in_ready` bits high.
- R2: With `cfg_we` high, the register chosen by `cfg_sel` is loaded with `cfg_data` on the clock edge. The selection codes are 0..7 for the pointer registers, 8 for index 0, 9 for index 1 and 10 for the block length. Codes 11..15 change nothing.
- R3: The offset is the zero-extended displacement when `u_src`=0, otherwise index register `u_idx` (0 or 1). `u_sub`=1 subtracts the offset and `u_sub`=0 adds it. Mode 0 (offset only) returns pointer ± offset and leaves the pointer unchanged.
- R4: Mode 1 (pre-modify) returns pointer ± offset and writes that value back to the pointer.
- R5: Mode 2 (post-modify) returns the old pointer and writes pointer ± offset back to it.
- R6: Mode 3 (circular) returns the old pointer. Let B be a nonzero block length and M = 2^k−1, where 2^k is the smallest power of two that is at least B. The new pointer keeps the bits above M and sets its low part to (low part ± offset) wrapped into 0..B−1, provided the low part starts below B and the offset is at most B. With B=0, mode 3 acts as mode 2.
- R7: Mode 4 (bit-reversed) returns the old pointer. The new pointer is the pointer plus index 0, with the carry propagating from bit 31 toward bit 0. Modes 5..7 behave as mode 0.
- R8: Both lanes can accept a request in the same cycle. Both read the register values held before that edge.
- R9: When both lanes write the same pointer in one cycle, lane 1's value is kept. A lane write overrides a configuration write to the same pointer in the same cycle.
- R10: While `out_valid` is high and `out_ready` is low, the lane holds `out_addr`, drives `in_ready` low and accepts nothing, so no pointer is updated.
- R11: The address appears on `out_addr` with `out_valid` high one cycle after acceptance. A pointer update is visible to a request accepted on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register load enable |
| cfg_sel | input | 4 | Register selection code |
| cfg_data | input | 32 | Value to load |
| in_valid | input | 2 | Per-lane request valid |
| in_ready | output | 2 | Per-lane request ready |
| u_ar | input | 6 | Pointer register number, 3 bits per lane |
| u_mode | input | 6 | Update mode, 3 bits per lane |
| u_src | input | 2 | Offset source per lane (0 displacement, 1 index) |
| u_idx | input | 2 | Index register choice per lane |
| u_sub | input | 2 | Subtract offset when 1 |
| u_disp | input | 16 | Displacement, 8 bits per lane |
| out_ready | input | 2 | Per-lane consumer ready |
| out_valid | output | 2 | Per-lane address valid |
| out_addr | output | 64 | Address, 32 bits per lane |

## Verification
A vector table applies each mode with both offset sources and both directions. Add and subtract cases separate sign handling, and displacement and index cases separate the offset multiplexer. Pointer read-back after each request tells write-back modes apart from the offset-only mode. Circular vectors cross the upper bound, go below zero and stay inside the block, which separates the wrap arithmetic from plain post-modify. Bit-reversed vectors with and without carry separate reversed-carry addition from ordinary addition. Directed cases then cover dual-lane issue to different pointers and to the same pointer, a collision between a configuration write and a lane write, output back-pressure, back-to-back dependent requests, ignored selection codes, and reset during a run.

// File: rtl/aag_pkg.sv
package aag_pkg;
  typedef enum logic [2:0] {
    M_OFS    = 3'd0,
    M_PREUPD = 3'd1,
    M_POST   = 3'd2,
    M_CIRC   = 3'd3,
    M_BREV   = 3'd4
  } aag_mode_e;
endpackage

// File: rtl/aag_regs.sv
module aag_regs #(
  parameter int NAR  = 8,
  parameter int AW   = 32,
  parameter int NU   = 2,
  parameter int ARW  = $clog2(NAR),
  parameter int SELW = $clog2(NAR + 3)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_we,
  input  logic [SELW-1:0]    cfg_sel,
  input  logic [AW-1:0]      cfg_data,
  input  logic [NU-1:0]      wr_en,
  input  logic [NU*ARW-1:0]  wr_idx,
  input  logic [NU*AW-1:0]   wr_val,
  output logic [NAR*AW-1:0]  ar_flat,
  output logic [AW-1:0]      ir0,
  output logic [AW-1:0]      ir1,
  output logic [AW-1:0]      bk
);
  localparam int SEL_IR0 = NAR;
  localparam int SEL_IR1 = NAR + 1;
  localparam int SEL_BK  = NAR + 2;

  logic [AW-1:0] ar_q [NAR];
  logic [AW-1:0] ir0_q, ir1_q, bk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NAR; i++) ar_q[i] <= '0;
      ir0_q <= '0;
      ir1_q <= '0;
      bk_q  <= '0;
    end else begin
      if (cfg_we) begin
        if (int'(cfg_sel) < NAR)         ar_q[cfg_sel[ARW-1:0]] <= cfg_data;
        else if (int'(cfg_sel) == SEL_IR0) ir0_q <= cfg_data;
        else if (int'(cfg_sel) == SEL_IR1) ir1_q <= cfg_data;
        else if (int'(cfg_sel) == SEL_BK)  bk_q  <= cfg_data;
      end
      // lanes later in the loop override earlier writers
      for (int u = 0; u < NU; u++)
        if (wr_en[u]) ar_q[wr_idx[u*ARW +: ARW]] <= wr_val[u*AW +: AW];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NAR; g++) begin : g_flat
      assign ar_flat[g*AW +: AW] = ar_q[g];
    end
  endgenerate

  assign ir0 = ir0_q;
  assign ir1 = ir1_q;
  assign bk  = bk_q;

  // R9
  last_lane_wins_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en[NU-1] |=> ar_q[$past(wr_idx[(NU-1)*ARW +: ARW])] == $past(wr_val[(NU-1)*AW +: AW]));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (ar_q[0] == '0 && ir0_q == '0 && ir1_q == '0 && bk_q == '0));
endmodule

// File: rtl/aag_unit.sv
module aag_unit
  import aag_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  aag_mode_e     mode,
  input  logic          src,
  input  logic          idx,
  input  logic          sub,
  input  logic [DW-1:0] disp,
  input  logic [AW-1:0] ar,
  input  logic [AW-1:0] ir0,
  input  logic [AW-1:0] ir1,
  input  logic [AW-1:0] bk,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [AW-1:0] out_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_val
);
  function automatic logic [AW-1:0] rev(input logic [AW-1:0] v);
    logic [AW-1:0] r;
    for (int i = 0; i < AW; i++) r[i] = v[AW-1-i];
    return r;
  endfunction

  logic          accept, upd;
  logic [AW-1:0] off, sum, mask, circ, brev, nxt_addr;
  logic [AW:0]   t;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_comb begin
    off = src ? (idx ? ir1 : ir0) : {{(AW-DW){1'b0}}, disp};
    sum = sub ? ar - off : ar + off;
    mask = bk - 1'b1;
    for (int s = 1; s < AW; s = s * 2) mask = mask | (mask >> s);
    if (!sub) begin
      t = {1'b0, ar & mask} + {1'b0, off};
      if (t >= {1'b0, bk}) t = t - {1'b0, bk};
    end else begin
      t = {1'b0, ar & mask} - {1'b0, off};
      if (t[AW]) t = t + {1'b0, bk};
    end
    circ = (bk == '0) ? sum : ((ar & ~mask) | t[AW-1:0]);
    brev = rev(rev(ar) + rev(ir0));
    case (mode)
      M_PREUPD: begin nxt_addr = sum; upd = 1'b1; wr_val = sum;  end
      M_POST:   begin nxt_addr = ar;  upd = 1'b1; wr_val = sum;  end
      M_CIRC:   begin nxt_addr = ar;  upd = 1'b1; wr_val = circ; end
      M_BREV:   begin nxt_addr = ar;  upd = 1'b1; wr_val = brev; end
      default:  begin nxt_addr = sum; upd = 1'b0; wr_val = sum;  end
    endcase
  end

  assign wr_en = accept && upd;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (accept) out_addr <= nxt_addr;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr)));

  // R10
  stall_no_write_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !wr_en);

  // R11
  accept_valid_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R6
  circ_region_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && mode == M_CIRC && bk != '0 && (ar & mask) < bk && off <= bk)
      |-> ((wr_val & ~mask) == (ar & ~mask) && (wr_val & mask) < bk));
endmodule

// File: rtl/aux_addr_gen.sv
module aux_addr_gen
  import aag_pkg::*;
#(
  parameter int NAR  = 8,
  parameter int AW   = 32,
  parameter int DW   = 8,
  parameter int NU   = 2,
  parameter int ARW  = $clog2(NAR),
  parameter int SELW = $clog2(NAR + 3)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [SELW-1:0]   cfg_sel,
  input  logic [AW-1:0]     cfg_data,
  input  logic [NU-1:0]     in_valid,
  output logic [NU-1:0]     in_ready,
  input  logic [NU*ARW-1:0] u_ar,
  input  logic [NU*3-1:0]   u_mode,
  input  logic [NU-1:0]     u_src,
  input  logic [NU-1:0]     u_idx,
  input  logic [NU-1:0]     u_sub,
  input  logic [NU*DW-1:0]  u_disp,
  input  logic [NU-1:0]     out_ready,
  output logic [NU-1:0]     out_valid,
  output logic [NU*AW-1:0]  out_addr
);
  logic [NAR*AW-1:0] ar_flat;
  logic [AW-1:0]     ir0, ir1, bk;
  logic [NU-1:0]     wr_en;
  logic [NU*AW-1:0]  wr_val;

  aag_regs #(.NAR(NAR), .AW(AW), .NU(NU), .ARW(ARW), .SELW(SELW)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .wr_en(wr_en), .wr_idx(u_ar), .wr_val(wr_val),
    .ar_flat(ar_flat), .ir0(ir0), .ir1(ir1), .bk(bk)
  );

  genvar g;
  generate
    for (g = 0; g < NU; g++) begin : g_lane
      logic [AW-1:0] ar_rd;
      assign ar_rd = ar_flat[u_ar[g*ARW +: ARW]*AW +: AW];

      aag_unit #(.AW(AW), .DW(DW)) u_lane (
        .clk(clk), .rst(rst),
        .in_valid(in_valid[g]), .in_ready(in_ready[g]),
        .mode(aag_mode_e'(u_mode[g*3 +: 3])),
        .src(u_src[g]), .idx(u_idx[g]), .sub(u_sub[g]),
        .disp(u_disp[g*DW +: DW]),
        .ar(ar_rd), .ir0(ir0), .ir1(ir1), .bk(bk),
        .out_ready(out_ready[g]), .out_valid(out_valid[g]),
        .out_addr(out_addr[g*AW +: AW]),
        .wr_en(wr_en[g]), .wr_val(wr_val[g*AW +: AW])
      );
    end
  endgenerate
endmodule

// File: tb/aux_addr_gen_test.sv
module aux_addr_gen_test;
  logic        clk = 0;
  logic        rst = 1;
  logic        cfg_we = 0;
  logic [3:0]  cfg_sel = 0;
  logic [31:0] cfg_data = 0;
  logic [1:0]  in_valid = 0, in_ready, out_ready = 2'b11, out_valid;
  logic [5:0]  u_ar = 0, u_mode = 0;
  logic [1:0]  u_src = 0, u_idx = 0, u_sub = 0;
  logic [15:0] u_disp = 0;
  logic [63:0] out_addr;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  aux_addr_gen uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .in_valid(in_valid), .in_ready(in_ready), .u_ar(u_ar), .u_mode(u_mode),
    .u_src(u_src), .u_idx(u_idx), .u_sub(u_sub), .u_disp(u_disp),
    .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr)
  );

  // {req, mode, src, idx, sub, disp, ar_init, exp_addr, exp_ar}
  localparam int NV = 12;
  localparam logic [113:0] VEC [NV] = '{
    {4'd3, 3'd0, 1'b0, 1'b0, 1'b0, 8'd5, 32'h1000, 32'h1005, 32'h1000},
    {4'd3, 3'd0, 1'b0, 1'b0, 1'b1, 8'd5, 32'h1000, 32'h0FFB, 32'h1000},
    {4'd3, 3'd0, 1'b1, 1'b1, 1'b0, 8'd0, 32'h1000, 32'h1100, 32'h1000},
    {4'd4, 3'd1, 1'b1, 1'b0, 1'b1, 8'd0, 32'h1000, 32'h0FF0, 32'h0FF0},
    {4'd5, 3'd2, 1'b0, 1'b0, 1'b0, 8'd7, 32'h1000, 32'h1000, 32'h1007},
    {4'd5, 3'd2, 1'b1, 1'b1, 1'b1, 8'd0, 32'h2000, 32'h2000, 32'h1F00},
    {4'd6, 3'd3, 1'b0, 1'b0, 1'b0, 8'd3, 32'h2008, 32'h2008, 32'h2001},
    {4'd6, 3'd3, 1'b0, 1'b0, 1'b1, 8'd4, 32'h2002, 32'h2002, 32'h2008},
    {4'd6, 3'd3, 1'b0, 1'b0, 1'b0, 8'd2, 32'h2003, 32'h2003, 32'h2005},
    {4'd7, 3'd4, 1'b0, 1'b0, 1'b0, 8'd0, 32'h0000, 32'h0000, 32'h0010},
    {4'd7, 3'd4, 1'b0, 1'b0, 1'b0, 8'd0, 32'h0018, 32'h0018, 32'h0004},
    {4'd7, 3'd6, 1'b0, 1'b0, 1'b0, 8'd9, 32'h0040, 32'h0049, 32'h0040}
  };

  task automatic chk(input int r, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s act=%h exp=%h", r, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [3:0] sel, input logic [31:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_data = d;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic setl(input int u, input logic [2:0] a, input logic [2:0] m,
                      input logic s, input logic ix, input logic sb, input logic [7:0] d);
    u_ar[u*3 +: 3] = a; u_mode[u*3 +: 3] = m; u_src[u] = s;
    u_idx[u] = ix; u_sub[u] = sb; u_disp[u*8 +: 8] = d;
  endtask

  task automatic issue0(input logic [2:0] a, input logic [2:0] m, input logic s,
                        input logic ix, input logic sb, input logic [7:0] d,
                        output logic [31:0] addr);
    setl(0, a, m, s, ix, sb, d);
    in_valid[0] = 1;
    @(posedge clk); @(negedge clk);
    in_valid[0] = 0;
    addr = out_addr[31:0];
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    issue0(a, 3'd0, 1'b0, 1'b0, 1'b0, 8'd0, v);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R10 watchdog expired act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk(1, "out_valid after reset", {30'd0, out_valid}, 32'd0);
    chk(1, "in_ready after reset", {30'd0, in_ready}, 32'd3);
    rd(3'd5, v); chk(1, "AR5 after reset", v, 32'h0);
    issue0(3'd5, 3'd0, 1'b1, 1'b1, 1'b0, 8'd0, v); chk(1, "IR1 after reset", v, 32'h0);

    cfg(4'd8, 32'h10); cfg(4'd9, 32'h100); cfg(4'd10, 32'd10);
    // R2 unused codes ignored
    cfg(4'd11, 32'hFFFF); cfg(4'd15, 32'hABCD);
    issue0(3'd5, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0, v); chk(2, "IR0 load / ignored code", v, 32'h10);
    issue0(3'd5, 3'd0, 1'b1, 1'b1, 1'b0, 8'd0, v); chk(2, "IR1 load / ignored code", v, 32'h100);
    rd(3'd5, v); chk(2, "AR5 untouched by ignored code", v, 32'h0);

    // table: R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [113:0] e;
      e = VEC[i];
      cfg(4'd3, e[95:64]);
      issue0(3'd3, e[109:107], e[106], e[105], e[104], e[103:96], v);
      chk(int'(e[113:110]), $sformatf("vector %0d addr", i), v, e[63:32]);
      rd(3'd3, v);
      chk(int'(e[113:110]), $sformatf("vector %0d pointer", i), v, e[31:0]);
    end

    // R8 two lanes, different pointers
    cfg(4'd1, 32'h100); cfg(4'd2, 32'h200);
    setl(0, 3'd1, 3'd2, 1'b0, 1'b0, 1'b0, 8'd1);
    setl(1, 3'd2, 3'd2, 1'b0, 1'b0, 1'b0, 8'd2);
    in_valid = 2'b11;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk(8, "lane0 addr", out_addr[31:0], 32'h100);
    chk(8, "lane1 addr", out_addr[63:32], 32'h200);
    rd(3'd1, v); chk(8, "AR1 updated", v, 32'h101);
    rd(3'd2, v); chk(8, "AR2 updated", v, 32'h202);

    // R9 same pointer from both lanes
    cfg(4'd4, 32'h300);
    setl(0, 3'd4, 3'd2, 1'b0, 1'b0, 1'b0, 8'd1);
    setl(1, 3'd4, 3'd2, 1'b0, 1'b0, 1'b0, 8'd2);
    in_valid = 2'b11;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    chk(8, "both lanes see old AR4 (lane0)", out_addr[31:0], 32'h300);
    chk(8, "both lanes see old AR4 (lane1)", out_addr[63:32], 32'h300);
    rd(3'd4, v); chk(9, "lane1 write kept", v, 32'h302);
    // R9 lane write beats configuration write
    cfg_we = 1; cfg_sel = 4'd4; cfg_data = 32'h999;
    setl(0, 3'd4, 3'd2, 1'b0, 1'b0, 1'b0, 8'd1);
    in_valid[0] = 1;
    @(posedge clk); @(negedge clk);
    in_valid[0] = 0; cfg_we = 0;
    rd(3'd4, v); chk(9, "lane over config", v, 32'h303);

    // R6 block length zero acts as post-modify
    cfg(4'd10, 32'd0); cfg(4'd3, 32'h2008);
    issue0(3'd3, 3'd3, 1'b0, 1'b0, 1'b0, 8'd9, v);
    rd(3'd3, v); chk(6, "circular with zero length", v, 32'h2011);

    // R10 back-pressure
    cfg(4'd5, 32'h0);
    out_ready[0] = 0;
    setl(0, 3'd5, 3'd0, 1'b0, 1'b0, 1'b0, 8'd1);
    in_valid[0] = 1;
    @(posedge clk); @(negedge clk);
    setl(0, 3'd5, 3'd2, 1'b0, 1'b0, 1'b0, 8'd9);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(10, "held valid", {31'd0, out_valid[0]}, 32'd1);
    chk(10, "held addr", out_addr[31:0], 32'h1);
    chk(10, "in_ready low", {31'd0, in_ready[0]}, 32'd0);
    in_valid[0] = 0; out_ready[0] = 1;
    @(posedge clk); @(negedge clk);
    rd(3'd5, v); chk(10, "no update while stalled", v, 32'h0);

    // R11 back-to-back dependent requests
    cfg(4'd6, 32'h50);
    setl(0, 3'd6, 3'd2, 1'b0, 1'b0, 1'b0, 8'd4);
    in_valid[0] = 1;
    @(posedge clk); @(negedge clk);
    chk(11, "first addr", out_addr[31:0], 32'h50);
    @(posedge clk); @(negedge clk);
    in_valid[0] = 0;
    chk(11, "second addr sees update", out_addr[31:0], 32'h54);
    rd(3'd6, v); chk(11, "final pointer", v, 32'h58);

    // R1 reset during a run
    rst = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 0;
    rd(3'd1, v); chk(1, "AR1 after run reset", v, 32'h0);
    issue0(3'd1, 3'd0, 1'b1, 1'b0, 1'b0, 8'd0, v); chk(1, "IR0 after run reset", v, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule